// File: doc/BRIEF.md
# Burst Write Data Accumulator

This block sits between a beat-rate write data path and a memory array whose write port is four beats wide. A write command carries a start address. The four data beats that follow, each with its own active-low write-enable lanes, are placed into four slots of one wide word. Once the fourth beat has been taken, the block raises a single array write. That write carries the wide word, one enable bit for every lane of every slot, and the row address.

In the wide variant, the two low command address bits choose the slot that the first beat fills. The remaining beats then fill the following slots in ascending order, wrapping from 3 back to 0. In the narrow variant, the low bits are ignored and the first beat always fills slot 0. If no lane is enabled in any of the four beats, the burst is an abort and no array write is issued. A new command may overlap the fourth beat of the current burst, which lets bursts run back to back. A command that arrives any earlier is refused and flagged.

Top module: `burst_accum`

## Requirements
- R1: After a command is accepted, the first four cycles with `beat_valid` high supply the beats. In the cycle after the fourth beat, `arr_we` is high for exactly one cycle, and slot s of `arr_data` (bits s*BEAT_W and up) holds the beat that landed in slot s.
- R2: With WIDE=1, the first beat lands in slot `cmd_addr[1:0]`, and each later beat lands in the next slot, modulo 4.
- R3: With WIDE=0, the first beat always lands in slot 0, whatever the value of `cmd_addr[1:0]`.
- R4: Lane l of a beat covers data bits l*(BEAT_W/LANES) and up. It is enabled when `beat_wen_n[l]` is 0. It is reported as active-high bit s*LANES+l of `arr_lane_en`, where s is the slot that beat landed in.
- R5: Each beat's mask is independent of the others. Enable bits from an earlier burst never carry into the map of a later burst.
- R6: If every lane is disabled in all four beats, `arr_we` stays low for that burst. `arr_we` is never high with an all-zero `arr_lane_en`.
- R7: While `arr_we` is high, `arr_row` equals `cmd_addr[ADDR_W+1:2]` of the burst's command.
- R8: A command presented in the same cycle as the fourth beat is accepted, and its first beat may follow in the very next cycle.
- R9: A command presented while a burst is collecting, before its fourth beat, is ignored. `cmd_err` is high for one cycle afterward, and the current burst completes with its own address.
- R10: `beat_valid` pulses while no burst is open are ignored.
- R11: After reset, `arr_we`, `cmd_err` and `arr_lane_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Write command strobe |
| cmd_addr | input | ADDR_W+2 | Command address: row in the upper bits, start slot in bits 1:0 |
| beat_valid | input | 1 | One data beat present |
| beat_data | input | BEAT_W | Beat data |
| beat_wen_n | input | LANES | Active-low lane write enables for this beat |
| arr_we | output | 1 | One-cycle array write request |
| arr_data | output | 4*BEAT_W | Wide write word, slot 0 in the low bits |
| arr_lane_en | output | 4*LANES | Active-high enable per slot and lane |
| arr_row | output | ADDR_W | Array row address |
| cmd_err | output | 1 | A command arrived before the fourth beat of the current burst |

## Verification
The bench sends every start offset and compares the wide and narrow variants side by side. A pointer that did not wrap, or that ignored the low address bits, would put beats in the wrong slots. Single-beat masks and an all-disabled burst are included: a design that shared one mask across beats, or that wrote on an abort, would produce a wrong enable map or a spurious `arr_we`. Back-to-back commands on the fourth beat test that the output map is not cleared or lost when the next burst starts. A command that arrives too early must raise `cmd_err` and must not steal the row address. Beats sent while idle must not open a burst.

// File: rtl/burst_accum_pkg.sv
// Shared constants and types for the burst write accumulator.
package burst_accum_pkg;
    localparam int SLOTS = 4;
    localparam int PTR_W = $clog2(SLOTS);
    typedef logic [PTR_W-1:0] slot_t;
endpackage

// File: rtl/beat_sequencer.sv
// Tracks one open burst: accepts commands, counts beats, steps the slot
// pointer and latches the row. Assumes at most one beat per cycle.
module beat_sequencer
    import burst_accum_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter bit WIDE   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W+1:0] cmd_addr,
    input  logic              beat_valid,
    output logic              take,
    output logic              last,
    output logic              accept,
    output slot_t             slot,
    output logic [ADDR_W-1:0] row,
    output logic              busy,
    output logic              cmd_err
);
    slot_t cnt;

    // Decode beat acceptance, the last beat and command acceptance.
    always_comb begin
        take   = busy && beat_valid;
        last   = take && (cnt == slot_t'(SLOTS - 1));
        accept = cmd_valid && (!busy || last);
    end

    // Advance burst state, beat count and slot pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            slot    <= '0;
            row     <= '0;
            cmd_err <= 1'b0;
        end else begin
            cmd_err <= cmd_valid && busy && !last;
            if (accept) begin
                busy <= 1'b1;
                cnt  <= '0;
                slot <= WIDE ? cmd_addr[PTR_W-1:0] : '0;
                row  <= cmd_addr[ADDR_W+1:2];
            end else if (take) begin
                cnt  <= cnt + 1'b1;
                slot <= slot + 1'b1;
                if (last) busy <= 1'b0;
            end
        end
    end

    // R9: an error flag always belongs to a burst that is still open.
    a_r9_err_while_open: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> busy);
    // R8: a command on the fourth beat keeps the sequencer open.
    a_r8_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (last && cmd_valid) |=> busy);
    // R2: the pointer steps by one slot per beat, wrapping.
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !accept) |=> (slot == slot_t'($past(slot) + 1'b1)));
endmodule

// File: rtl/slot_bank.sv
// Holds the four beat slots and their lane enables for the open burst,
// and presents the merged view that includes the beat being taken now.
// Assumes clear and take coincide only on a fourth beat.
module slot_bank
    import burst_accum_pkg::*;
#(
    parameter int BEAT_W = 8,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      take,
    input  slot_t                     slot,
    input  logic [BEAT_W-1:0]         beat_data,
    input  logic [LANES-1:0]          beat_wen_n,
    output logic [SLOTS*BEAT_W-1:0]   merged_data,
    output logic [SLOTS*LANES-1:0]    merged_en
);
    logic [SLOTS*BEAT_W-1:0] acc_data;
    logic [SLOTS*LANES-1:0]  acc_en;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = take && (slot == slot_t'(s));

        // Merge the incoming beat over the stored slot contents.
        always_comb begin
            merged_data[s*BEAT_W +: BEAT_W] = hit ? beat_data : acc_data[s*BEAT_W +: BEAT_W];
            merged_en[s*LANES +: LANES]     = hit ? ~beat_wen_n : acc_en[s*LANES +: LANES];
        end

        // Store a beat into this slot; a new command clears its enables.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_data[s*BEAT_W +: BEAT_W] <= '0;
                acc_en[s*LANES +: LANES]     <= '0;
            end else begin
                if (hit) acc_data[s*BEAT_W +: BEAT_W] <= beat_data;
                if (clear) acc_en[s*LANES +: LANES] <= '0;
                else if (hit) acc_en[s*LANES +: LANES] <= ~beat_wen_n;
            end
        end
    end

    // R5: a new burst starts with every slot's enables inactive.
    a_r5_clear_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !take) |=> (acc_en == '0));
endmodule

// File: rtl/burst_accum.sv
// Burst write accumulator top. Collects four beats into one wide word
// and issues one masked array write, or none if the burst is an abort.
// Assumes beats arrive one per cycle on beat_valid after the command.
module burst_accum
    import burst_accum_pkg::*;
#(
    parameter int BEAT_W = 8,
    parameter int LANES  = 2,
    parameter int ADDR_W = 20,
    parameter bit WIDE   = 1'b1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [ADDR_W+1:0]         cmd_addr,
    input  logic                      beat_valid,
    input  logic [BEAT_W-1:0]         beat_data,
    input  logic [LANES-1:0]          beat_wen_n,
    output logic                      arr_we,
    output logic [SLOTS*BEAT_W-1:0]   arr_data,
    output logic [SLOTS*LANES-1:0]    arr_lane_en,
    output logic [ADDR_W-1:0]         arr_row,
    output logic                      cmd_err
);
    logic              take, last, accept, busy;
    slot_t             slot;
    logic [ADDR_W-1:0] row;
    logic [SLOTS*BEAT_W-1:0] merged_data;
    logic [SLOTS*LANES-1:0]  merged_en;

    beat_sequencer #(.ADDR_W(ADDR_W), .WIDE(WIDE)) i_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .beat_valid(beat_valid), .take(take), .last(last), .accept(accept),
        .slot(slot), .row(row), .busy(busy), .cmd_err(cmd_err)
    );

    slot_bank #(.BEAT_W(BEAT_W), .LANES(LANES)) i_bank (
        .clk(clk), .rst_n(rst_n), .clear(accept), .take(take), .slot(slot),
        .beat_data(beat_data), .beat_wen_n(beat_wen_n),
        .merged_data(merged_data), .merged_en(merged_en)
    );

    // Launch the array write once the fourth beat is in; drop aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arr_we      <= 1'b0;
            arr_data    <= '0;
            arr_lane_en <= '0;
            arr_row     <= '0;
        end else begin
            arr_we <= last && (|merged_en);
            if (last) begin
                arr_data    <= merged_data;
                arr_lane_en <= merged_en;
                arr_row     <= row;
            end
        end
    end

    // R1: the array write is a single-cycle pulse.
    a_r1_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |=> !arr_we);
    // R6: a write always carries at least one enabled lane.
    a_r6_no_empty_write: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (|arr_lane_en));
    // R1: a write follows only a burst that was open on the previous edge.
    a_r1_we_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_we) |-> $past(busy));
endmodule

// File: tb/test_burst_accum.sv
module test_burst_accum;
    localparam int BW = 8, LN = 2, AW = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, beat_valid = 1'b0;
    logic [AW+1:0] cmd_addr = '0;
    logic [BW-1:0] beat_data = '0;
    logic [LN-1:0] beat_wen_n = '1;
    logic w_we, n_we, w_err, n_err;
    logic [4*BW-1:0] w_data, n_data;
    logic [4*LN-1:0] w_en, n_en;
    logic [AW-1:0] w_row, n_row;

    int tests = 0, fails = 0;
    logic [4*BW-1:0] ew_data, en_data;
    logic [4*LN-1:0] ew_en, en_en;

    always #2 clk = ~clk;

    burst_accum #(.BEAT_W(BW), .LANES(LN), .ADDR_W(AW), .WIDE(1'b1)) i_burst_accum (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .beat_valid(beat_valid), .beat_data(beat_data), .beat_wen_n(beat_wen_n),
        .arr_we(w_we), .arr_data(w_data), .arr_lane_en(w_en), .arr_row(w_row),
        .cmd_err(w_err));

    burst_accum #(.BEAT_W(BW), .LANES(LN), .ADDR_W(AW), .WIDE(1'b0)) i_narrow (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .beat_valid(beat_valid), .beat_data(beat_data), .beat_wen_n(beat_wen_n),
        .arr_we(n_we), .arr_data(n_data), .arr_lane_en(n_en), .arr_row(n_row),
        .cmd_err(n_err));

    // Vector: {addr[21:0], seed[7:0], wen_n per beat[7:0] (beat i at bits 2i+1:2i)}
    localparam logic [37:0] VEC [0:5] = '{
        {22'h000010, 8'h10, 8'b00_00_00_00},
        {22'h000021, 8'h20, 8'b00_00_00_00},
        {22'h000032, 8'h30, 8'b11_11_11_00},
        {22'h000043, 8'h40, 8'b00_11_11_11},
        {22'h3FFFF5, 8'hA0, 8'b10_01_11_11},
        {22'h12345E, 8'h55, 8'b11_01_10_11}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected slot placement for both variants, built from R2/R3/R4.
    task automatic expect_for(input logic [1:0] lo, input logic [7:0] seed, input logic [7:0] wen);
        ew_data = '0; en_data = '0; ew_en = '0; en_en = '0;
        for (int i = 0; i < 4; i++) begin
            int sw = (int'(lo) + i) % 4;
            ew_data[sw*BW +: BW] = seed + 8'(i * 8'h11);
            en_data[i*BW +: BW]  = seed + 8'(i * 8'h11);
            ew_en[sw*LN +: LN]   = ~wen[2*i +: 2];
            en_en[i*LN +: LN]    = ~wen[2*i +: 2];
        end
    endtask

    task automatic beat(input int i, input logic [7:0] seed, input logic [7:0] wen);
        beat_valid = 1'b1;
        beat_data  = seed + 8'(i * 8'h11);
        beat_wen_n = wen[2*i +: 2];
    endtask

    task automatic check_out(input string tag, input logic [21:0] addr);
        logic exp_we;
        exp_we = |ew_en;
        check({tag, " R1/R6 wide we"}, 64'(w_we), 64'(exp_we));
        check({tag, " R3/R6 narrow we"}, 64'(n_we), 64'(exp_we));
        if (exp_we) begin
            check({tag, " R2 wide data"}, 64'(w_data), 64'(ew_data));
            check({tag, " R4 R5 wide lane map"}, 64'(w_en), 64'(ew_en));
            check({tag, " R3 narrow data"}, 64'(n_data), 64'(en_data));
            check({tag, " R3 narrow lane map"}, 64'(n_en), 64'(en_en));
            check({tag, " R7 row"}, 64'(w_row), 64'(addr[21:2]));
        end
    endtask

    task automatic run_burst(input string tag, input logic [21:0] addr, input logic [7:0] seed, input logic [7:0] wen);
        @(negedge clk); cmd_valid = 1'b1; cmd_addr = addr;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); cmd_valid = 1'b0; beat(i, seed, wen);
        end
        @(negedge clk); beat_valid = 1'b0; beat_wen_n = '1;
        expect_for(addr[1:0], seed, wen);
        check_out(tag, addr);
        @(negedge clk);
        check({tag, " R1 pulse ends"}, 64'(w_we), 64'd0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        check("R11 reset we", 64'(w_we), 64'd0);
        check("R11 reset err", 64'(w_err), 64'd0);
        check("R11 reset lane map", 64'(w_en), 64'd0);
        rst_n = 1'b1;

        // Table walk: R1..R7 over all start offsets and masks.
        for (int v = 0; v < 6; v++)
            run_burst($sformatf("vec%0d", v), VEC[v][37:16], VEC[v][15:8], VEC[v][7:0]);

        // R6 abort: every lane disabled in all four beats.
        run_burst("R6 abort", 22'h000102, 8'h77, 8'hFF);

        // R10: beats while idle are ignored.
        @(negedge clk); beat(0, 8'hEE, 8'h00);
        @(negedge clk); beat(1, 8'hEE, 8'h00);
        @(negedge clk); beat_valid = 1'b0;
        check("R10 no write from idle beats", 64'(w_we), 64'd0);
        run_burst("R10 after idle", 22'h000203, 8'h61, 8'h00);

        // R8: second command on the fourth beat of the first.
        @(negedge clk); cmd_valid = 1'b1; cmd_addr = 22'h000301;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); cmd_valid = 1'b0; beat(i, 8'h81, 8'b00_10_01_00);
        end
        @(negedge clk); beat(3, 8'h81, 8'b00_10_01_00); cmd_valid = 1'b1; cmd_addr = 22'h000402;
        @(negedge clk); cmd_valid = 1'b0; beat(0, 8'hC3, 8'b01_00_00_10);
        expect_for(2'd1, 8'h81, 8'b00_10_01_00);
        check_out("R8 first", 22'h000301);
        check("R8 no error", 64'(w_err), 64'd0);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk); beat(i, 8'hC3, 8'b01_00_00_10);
        end
        @(negedge clk); beat_valid = 1'b0; beat_wen_n = '1;
        expect_for(2'd2, 8'hC3, 8'b01_00_00_10);
        check_out("R8 second", 22'h000402);

        // R9: early command is flagged and ignored.
        @(negedge clk); cmd_valid = 1'b1; cmd_addr = 22'h000503;
        @(negedge clk); cmd_valid = 1'b0; beat(0, 8'h19, 8'h00);
        @(negedge clk); beat(1, 8'h19, 8'h00); cmd_valid = 1'b1; cmd_addr = 22'h000600;
        @(negedge clk); cmd_valid = 1'b0; beat(2, 8'h19, 8'h00);
        check("R9 err raised", 64'(w_err), 64'd1);
        @(negedge clk); beat(3, 8'h19, 8'h00);
        check("R9 err one cycle", 64'(w_err), 64'd0);
        @(negedge clk); beat_valid = 1'b0; beat_wen_n = '1;
        expect_for(2'd3, 8'h19, 8'h00);
        check_out("R9 burst kept", 22'h000503);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule